// File: doc/BRIEF.md
# PLL Lock Timer and Bypass Controller

This block follows the lock state of a PLL whose output is a multiple of a slow reference clock. Software writes a configuration word with an 11-bit multiplier field, an 8-bit settle-count field and an interrupt-enable bit. When a write carries a multiplier that differs from the one held, the block reloads an 8-bit down-counter from the settle-count field, drops its lock flag and routes the clock path to the slow clock. The counter runs on the slow clock. When it reaches zero, the lock flag rises, the bypass is released and an interrupt pulse may be issued.

A multiplier of zero turns the PLL off and keeps it bypassed. The block drives only the enable, bypass and lock indications, plus the effective multiply factor for the PLL model. Everything runs on the slow clock.

The control is a three-state machine. The states are `ST_OFF` (PLL powered down), `ST_SETTLE` (countdown running) and `ST_LOCKED`. The transitions are as follows:
- any state goes to `ST_OFF` on a write that changes the multiplier to zero;
- any state goes to `ST_SETTLE` on a write that changes the multiplier to a nonzero value;
- `ST_SETTLE` goes to `ST_LOCKED` when the counter is found at zero;
- a write that keeps the multiplier leaves every state where it is.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset, `pll_en` = 0, `pll_bypass` = 1, `pll_lock` = 0, `lock_irq` = 0 and `pll_factor` = 1.
- R2: `pll_factor` equals the last written multiplier plus one, as a 12-bit value, so a field of 2047 gives 2048.
- R3: A write whose multiplier is nonzero and differs from the held one makes `pll_lock` = 0, `pll_bypass` = 1 and `pll_en` = 1 from the clock edge that captures the write.
- R4: After such a write with settle count N captured at edge W, `pll_lock` stays 0 through edge W+N and becomes 1 at edge W+N+1. A count of 0 therefore locks on the very next edge.
- R5: A write whose multiplier equals the held one does not restart the countdown and does not change `pll_lock`.
- R6: `lock_irq` is a one-cycle pulse issued at the same edge where `pll_lock` rises. It is issued only if the interrupt-enable bit of the most recent earlier write is 1.
- R7: A write that changes the multiplier to 0 makes `pll_en` = 0, `pll_bypass` = 1 and `pll_lock` = 0, and they stay that way until another changing write.
- R8: `pll_bypass` is always the inverse of `pll_lock`.
- R9: A changing write during a countdown restarts it with the newly written settle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mult | input | 11 | Multiplier field (factor minus one) |
| cfg_settle | input | 8 | Settle count loaded into the lock timer |
| cfg_irq_en | input | 1 | Lock interrupt enable |
| pll_en | output | 1 | PLL powered on |
| pll_bypass | output | 1 | Clock path uses the slow clock |
| pll_lock | output | 1 | PLL considered locked |
| lock_irq | output | 1 | One-cycle lock interrupt pulse |
| pll_factor | output | 12 | Effective multiply factor |

## Verification
A corrupted state register shows up at once on the enable, bypass or lock pins, because all three are decoded straight from the state. A wrong count or a faulty reload in the timer shows up as a lock edge one or more cycles away from W+N+1. The scoreboard therefore checks the cycle just before the expected lock edge and the cycle of the edge itself. A wrong comparison of the held multiplier shows up as a lock that drops after a write that repeats the value, or as a countdown that fails to restart.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_t;
endpackage

// File: rtl/pll_settle_timer.sv
module pll_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             at_zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign at_zero = (cnt_q == '0);

    // R4: a reload takes the written settle count
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
    // R4: the timer never wraps below zero
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && at_zero) |=> at_zero);
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
    import pll_lock_pkg::*;
#(
    parameter int MULT_W = 11,
    parameter int CNT_W  = 8
) (
    input  logic              clk_slow,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic [CNT_W-1:0]  cfg_settle,
    input  logic              cfg_irq_en,
    output logic              pll_en,
    output logic              pll_bypass,
    output logic              pll_lock,
    output logic              lock_irq,
    output logic [MULT_W:0]   pll_factor
);
    localparam int FACT_W = MULT_W + 1;

    lock_state_t state_q, state_d;
    logic [MULT_W-1:0] mult_q;
    logic              irq_en_q;
    logic              irq_q;
    logic              mult_change;
    logic              tmr_load;
    logic              tmr_zero;

    assign mult_change = cfg_wr && (cfg_mult != mult_q);
    assign tmr_load    = mult_change && (cfg_mult != '0);

    pll_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk_slow),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (cfg_settle),
        .run      (state_q == ST_SETTLE),
        .at_zero  (tmr_zero)
    );

    always_comb begin
        state_d = state_q;
        if (mult_change) begin
            state_d = (cfg_mult == '0) ? ST_OFF : ST_SETTLE;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_OFF;
                ST_SETTLE: state_d = tmr_zero ? ST_LOCKED : ST_SETTLE;
                ST_LOCKED: state_d = ST_LOCKED;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            mult_q   <= '0;
            irq_en_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_en_q && (state_q == ST_SETTLE) && (state_d == ST_LOCKED);
            if (cfg_wr) begin
                mult_q   <= cfg_mult;
                irq_en_q <= cfg_irq_en;
            end
        end
    end

    always_comb begin
        pll_en     = (state_q != ST_OFF);
        pll_lock   = (state_q == ST_LOCKED);
        pll_bypass = !pll_lock;
        lock_irq   = irq_q;
        pll_factor = FACT_W'(mult_q) + FACT_W'(1);
    end

    // R6: an interrupt pulse only accompanies a rising lock
    a_r6_irq_on_rise: assert property (@(posedge clk_slow) disable iff (!rst_n)
        lock_irq |-> (pll_lock && !$past(pll_lock)));
    // R6: the pulse lasts one cycle
    a_r6_irq_single: assert property (@(posedge clk_slow) disable iff (!rst_n)
        lock_irq |=> !lock_irq);
    // R3: a changing nonzero write unlocks and powers the PLL
    a_r3_change_unlocks: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (cfg_wr && cfg_mult != '0 && FACT_W'(cfg_mult) + FACT_W'(1) != pll_factor)
        |=> (!pll_lock && pll_en));
    // R5: repeating the held multiplier keeps the lock
    a_r5_same_keeps_lock: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (cfg_wr && FACT_W'(cfg_mult) + FACT_W'(1) == pll_factor && pll_lock) |=> pll_lock);
    // R7: a powered-down PLL is never locked
    a_r7_off_unlocked: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !pll_en |-> !pll_lock);
endmodule

// File: tb/tb_pll_lock_ctrl.sv
module tb_pll_lock_ctrl;
    logic        clk_slow = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [10:0] cfg_mult;
    logic [7:0]  cfg_settle;
    logic        cfg_irq_en;
    logic        pll_en, pll_bypass, pll_lock, lock_irq;
    logic [11:0] pll_factor;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    typedef struct {
        int          at;
        bit          lock;
        bit          irq;
        bit          en;
        logic [11:0] factor;
        string       req;
    } exp_t;
    exp_t sb[$];

    pll_lock_ctrl dut (
        .clk_slow(clk_slow), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mult(cfg_mult),
        .cfg_settle(cfg_settle), .cfg_irq_en(cfg_irq_en), .pll_en(pll_en),
        .pll_bypass(pll_bypass), .pll_lock(pll_lock), .lock_irq(lock_irq),
        .pll_factor(pll_factor)
    );

    always #2 clk_slow = ~clk_slow;
    always @(posedge clk_slow) cyc <= cyc + 1;

    task automatic check_now(bit lk, bit irq, bit en, logic [11:0] fac, string req);
        n_tests++;
        if (pll_lock !== lk || lock_irq !== irq || pll_en !== en ||
            pll_bypass !== !lk || pll_factor !== fac) begin
            n_fail++;
            $display("FAIL %s: got lock=%0b irq=%0b en=%0b byp=%0b fac=%0d exp lock=%0b irq=%0b en=%0b byp=%0b fac=%0d",
                     req, pll_lock, lock_irq, pll_en, pll_bypass, pll_factor,
                     lk, irq, en, !lk, fac);
        end
    endtask

    task automatic expect_at(int at, bit lk, bit irq, bit en, logic [11:0] fac, string req);
        exp_t e;
        e.at = at; e.lock = lk; e.irq = irq; e.en = en; e.factor = fac; e.req = req;
        sb.push_back(e);
    endtask

    // Drives one write at a falling edge; returns the cycle number of the capturing edge
    task automatic write_cfg(logic [10:0] m, logic [7:0] s, bit ie, output int w);
        w = cyc + 1;
        cfg_wr = 1'b1; cfg_mult = m; cfg_settle = s; cfg_irq_en = ie;
        @(negedge clk_slow);
        cfg_wr = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk_slow);
    endtask

    // Monitor: pops expected items as their cycle comes up
    always @(negedge clk_slow) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            if (e.at < cyc) begin
                n_tests++; n_fail++;
                $display("FAIL %s: item for cycle %0d missed, now %0d", e.req, e.at, cyc);
            end else begin
                check_now(e.lock, e.irq, e.en, e.factor, e.req);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int w, w2;
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_mult = '0; cfg_settle = '0; cfg_irq_en = 1'b0;
        idle(3);
        check_now(1'b0, 1'b0, 1'b0, 12'd1, "R1 reset");
        rst_n = 1'b1;
        idle(2);
        check_now(1'b0, 1'b0, 1'b0, 12'd1, "R1 after release");

        // R2 R3 R4 R6: multiplier 5, settle 3, interrupt on
        write_cfg(11'd5, 8'd3, 1'b1, w);
        expect_at(w,     1'b0, 1'b0, 1'b1, 12'd6, "R3 unlock on change");
        expect_at(w + 3, 1'b0, 1'b0, 1'b1, 12'd6, "R4 not yet locked");
        expect_at(w + 4, 1'b1, 1'b1, 1'b1, 12'd6, "R4 R6 lock with irq");
        expect_at(w + 5, 1'b1, 1'b0, 1'b1, 12'd6, "R6 irq single cycle");
        idle(8);

        // R5: same multiplier, large settle count, stays locked
        write_cfg(11'd5, 8'd50, 1'b1, w);
        expect_at(w,     1'b1, 1'b0, 1'b1, 12'd6, "R5 same value keeps lock");
        expect_at(w + 3, 1'b1, 1'b0, 1'b1, 12'd6, "R5 no restart");
        idle(6);

        // R2 R4 R6: max multiplier, zero settle count, interrupt off
        write_cfg(11'd2047, 8'd0, 1'b0, w);
        expect_at(w,     1'b0, 1'b0, 1'b1, 12'd2048, "R2 R3 factor 2048 unlocked");
        expect_at(w + 1, 1'b1, 1'b0, 1'b1, 12'd2048, "R4 R6 zero count locks next edge without irq");
        idle(4);

        // R7: zero multiplier powers down
        write_cfg(11'd0, 8'd9, 1'b1, w);
        expect_at(w,      1'b0, 1'b0, 1'b0, 12'd1, "R7 power down");
        expect_at(w + 12, 1'b0, 1'b0, 1'b0, 12'd1, "R7 stays down");
        idle(16);

        // R9: restart mid-countdown with new settle count
        write_cfg(11'd7, 8'd10, 1'b1, w);
        idle(3);
        write_cfg(11'd8, 8'd2, 1'b1, w2);
        expect_at(w2,     1'b0, 1'b0, 1'b1, 12'd9, "R9 restart unlocked");
        expect_at(w2 + 2, 1'b0, 1'b0, 1'b1, 12'd9, "R9 before new lock");
        expect_at(w2 + 3, 1'b1, 1'b1, 1'b1, 12'd9, "R9 R8 lock from new count");
        idle(16);

        if (sb.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule